// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number paired with an offset inside that segment, into a flat physical address. It keeps a small segment table in local flip-flops. Each slot of the table records where the segment starts in physical memory, how long it is, whether the slot is in use, and which kinds of access it permits. A separate length register states how many of the low-numbered slots a program may use.

Software fills the table through a configuration port. This port offers one strobe for writing a single slot and another for loading the length register. The translation port takes a segment number, an offset and an access kind. Exactly one clock later the block returns either a physical address or a trap with a two-bit cause. That result is meant to reach the kernel's fault handling.

Top module: `segxlat_top`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high on the following cycle. `rsp_valid` is low in every other cycle, and while it is low, `rsp_trap` and `rsp_cause` are zero.
- R2: A segment number that is equal to or greater than the length register traps with cause 2'b01.
- R3: A segment number below the length register whose slot is marked not valid also traps with cause 2'b01.
- R4: An offset equal to or greater than the slot's limit traps with cause 2'b10. An offset one below the limit is accepted.
- R5: The access kind is encoded as 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 reserved. The slot's permission bits are bit 0 read, bit 1 write and bit 2 execute. An access whose permission bit is clear traps with cause 2'b11, and the reserved kind always traps with cause 2'b11.
- R6: When several faults apply at once, the segment fault (R2 or R3) wins over the limit fault, and the limit fault wins over the permission fault.
- R7: A legal access returns `rsp_trap` = 0, `rsp_cause` = 2'b00 and `rsp_paddr` = base + offset, taken modulo 2^PA_W.
- R8: Whenever `rsp_trap` is high, `rsp_paddr` is zero.
- R9: After reset every slot is not valid, the length register is zero and `rsp_valid` is low. Any request then traps with cause 2'b01.
- R10: A slot write or length write affects requests from the next cycle onward. A request in the same cycle as a write is translated with the old table contents.
- R11: A slot write changes only the slot it addresses. Every other slot keeps its base, limit, permissions and valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ent_we | input | 1 | Write one table slot this cycle |
| cfg_ent_idx | input | SEG_W | Slot to write |
| cfg_ent_base | input | PA_W | Physical start address of the segment |
| cfg_ent_limit | input | OFS_W+1 | Segment length in address units |
| cfg_ent_perm | input | 3 | Permission bits: execute, write, read |
| cfg_ent_valid | input | 1 | Slot in use |
| cfg_len_we | input | 1 | Load the length register |
| cfg_len_val | input | SEG_W+1 | Number of usable slots |
| req_valid | input | 1 | Translation request present |
| req_seg | input | SEG_W | Segment number |
| req_ofs | input | OFS_W | Offset inside the segment |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Result present |
| rsp_trap | output | 1 | Access refused |
| rsp_cause | output | 2 | Refusal reason, 2'b00 when accepted |
| rsp_paddr | output | PA_W | Translated physical address, zero on trap |

## Verification
Each translation result appears on the outputs one clock edge after the cycle in which its request is driven. A configuration write is visible to a request driven one cycle after the write. The driver applies inputs on falling edges and pushes the expected result into a queue at the same moment. The monitor pops that queue on the next falling edge, and it also checks that `rsp_valid` matches the request strobe captured at the rising edge in between. A dedicated case drives a slot write and a request in the same cycle, then repeats the request one cycle later, to pin down the exact cycle in which the new contents take effect.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_SEG  = 2'b01,
        CAUSE_LIM  = 2'b10,
        CAUSE_PERM = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_RSV = 2'b11
    } acc_e;

    localparam int PERM_W  = 3;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

    function automatic logic perm_allows(input logic [1:0] acc, input logic [PERM_W-1:0] perm);
        logic ok;
        case (acc)
            ACC_RD:  ok = perm[PERM_RD];
            ACC_WR:  ok = perm[PERM_WR];
            ACC_EX:  ok = perm[PERM_EX];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/segxlat_table.sv
module segxlat_table
    import segxlat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16,
    parameter int LIM_W = 13,
    localparam int NSEG  = 1 << SEG_W,
    localparam int LEN_W = SEG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [PA_W-1:0]   wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_valid,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [PA_W-1:0]   rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic [PERM_W-1:0] rd_perm,
    output logic              rd_valid,
    output logic [LEN_W-1:0]  len_q
);

    typedef struct packed {
        logic              valid;
        logic [PERM_W-1:0] perm;
        logic [LIM_W-1:0]  limit;
        logic [PA_W-1:0]   base;
    } slot_t;

    slot_t slots_q [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_idx == SEG_W'(i))) begin
                slot_d.valid = wr_valid;
                slot_d.perm  = wr_perm;
                slot_d.limit = wr_limit;
                slot_d.base  = wr_base;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign slots_q[i] = slot_q;
    end

    logic [LEN_W-1:0] len_d;

    always_comb begin
        len_d = len_q;
        if (len_we) len_d = len_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    slot_t sel;
    assign sel      = slots_q[rd_idx];
    assign rd_base  = sel.base;
    assign rd_limit = sel.limit;
    assign rd_perm  = sel.perm;
    assign rd_valid = sel.valid;

endmodule

// File: rtl/segxlat_check.sv
module segxlat_check
    import segxlat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFS_W = 12,
    parameter int PA_W  = 16,
    localparam int LIM_W = OFS_W + 1,
    localparam int LEN_W = SEG_W + 1
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [1:0]        acc,
    input  logic [LEN_W-1:0]  len,
    input  logic [PA_W-1:0]   base,
    input  logic [LIM_W-1:0]  limit,
    input  logic [PERM_W-1:0] perm,
    input  logic              present,
    output logic              trap,
    output logic [1:0]        cause,
    output logic [PA_W-1:0]   paddr
);

    logic   seg_bad, lim_bad, perm_bad;
    cause_e why;

    assign seg_bad  = ({1'b0, seg} >= len) || !present;
    assign lim_bad  = ({1'b0, ofs} >= limit);
    assign perm_bad = !perm_allows(acc, perm);

    always_comb begin
        if (seg_bad)       why = CAUSE_SEG;
        else if (lim_bad)  why = CAUSE_LIM;
        else if (perm_bad) why = CAUSE_PERM;
        else               why = CAUSE_NONE;
    end

    assign trap  = (why != CAUSE_NONE);
    assign cause = why;
    assign paddr = base + PA_W'(ofs);

endmodule

// File: rtl/segxlat_top.sv
module segxlat_top
    import segxlat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFS_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ent_we,
    input  logic [SEG_W-1:0] cfg_ent_idx,
    input  logic [PA_W-1:0]  cfg_ent_base,
    input  logic [OFS_W:0]   cfg_ent_limit,
    input  logic [2:0]       cfg_ent_perm,
    input  logic             cfg_ent_valid,
    input  logic             cfg_len_we,
    input  logic [SEG_W:0]   cfg_len_val,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic             rsp_trap,
    output logic [1:0]       rsp_cause,
    output logic [PA_W-1:0]  rsp_paddr
);

    localparam int LIM_W = OFS_W + 1;
    localparam int LEN_W = SEG_W + 1;

    typedef struct packed {
        logic            valid;
        logic            trap;
        logic [1:0]      cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    logic [PA_W-1:0]   ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic [PERM_W-1:0] ent_perm;
    logic              ent_present;
    logic [LEN_W-1:0]  tbl_len;

    segxlat_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_ent_we),
        .wr_idx   (cfg_ent_idx),
        .wr_base  (cfg_ent_base),
        .wr_limit (cfg_ent_limit),
        .wr_perm  (cfg_ent_perm),
        .wr_valid (cfg_ent_valid),
        .len_we   (cfg_len_we),
        .len_val  (cfg_len_val),
        .rd_idx   (req_seg),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_perm  (ent_perm),
        .rd_valid (ent_present),
        .len_q    (tbl_len)
    );

    logic            chk_trap;
    logic [1:0]      chk_cause;
    logic [PA_W-1:0] chk_paddr;

    segxlat_check #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_check (
        .seg     (req_seg),
        .ofs     (req_ofs),
        .acc     (req_acc),
        .len     (tbl_len),
        .base    (ent_base),
        .limit   (ent_limit),
        .perm    (ent_perm),
        .present (ent_present),
        .trap    (chk_trap),
        .cause   (chk_cause),
        .paddr   (chk_paddr)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.trap  = chk_trap;
            rsp_d.cause = chk_cause;
            rsp_d.paddr = chk_trap ? '0 : chk_paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_trap  = rsp_q.trap;
    assign rsp_cause = rsp_q.cause;
    assign rsp_paddr = rsp_q.paddr;

endmodule

// File: rtl/segxlat_props.sv
module segxlat_props #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic             cfg_len_we,
    input logic [SEG_W:0]   cfg_len_val,
    input logic [SEG_W:0]   tbl_len,
    input logic             rsp_valid,
    input logic             rsp_trap,
    input logic [1:0]       rsp_cause,
    input logic [PA_W-1:0]  rsp_paddr
);

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_trap && rsp_cause == 2'b00));

    a_r2_seg_over_len: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= tbl_len)) |=> (rsp_trap && rsp_cause == 2'b01));

    a_r7_accept_cause_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_trap) |-> (rsp_cause == 2'b00));

    a_r8_trap_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_paddr == '0 && rsp_cause != 2'b00));

    a_r10_len_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_len_we |=> (tbl_len == $past(cfg_len_val)));

endmodule

bind segxlat_top segxlat_props #(.SEG_W(SEG_W), .PA_W(PA_W)) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_seg     (req_seg),
    .cfg_len_we  (cfg_len_we),
    .cfg_len_val (cfg_len_val),
    .tbl_len     (tbl_len),
    .rsp_valid   (rsp_valid),
    .rsp_trap    (rsp_trap),
    .rsp_cause   (rsp_cause),
    .rsp_paddr   (rsp_paddr)
);

// File: tb/segxlat_top_test.sv
`timescale 1ns/1ps
module segxlat_top_test;

    localparam int SEG_W = 3;
    localparam int OFS_W = 12;
    localparam int PA_W  = 16;
    localparam int NSEG  = 1 << SEG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_ent_we = 1'b0;
    logic [SEG_W-1:0] cfg_ent_idx = '0;
    logic [PA_W-1:0]  cfg_ent_base = '0;
    logic [OFS_W:0]   cfg_ent_limit = '0;
    logic [2:0]       cfg_ent_perm = '0;
    logic             cfg_ent_valid = 1'b0;
    logic             cfg_len_we = 1'b0;
    logic [SEG_W:0]   cfg_len_val = '0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFS_W-1:0] req_ofs = '0;
    logic [1:0]       req_acc = '0;
    logic             rsp_valid;
    logic             rsp_trap;
    logic [1:0]       rsp_cause;
    logic [PA_W-1:0]  rsp_paddr;

    always #2.5 clk = ~clk;

    segxlat_top #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) uut (.*);

    // bench model of the table
    logic [PA_W-1:0] m_base  [NSEG];
    logic [OFS_W:0]  m_limit [NSEG];
    logic [2:0]      m_perm  [NSEG];
    logic            m_valid [NSEG];
    logic [SEG_W:0]  m_len;

    typedef struct packed {
        logic            trap;
        logic [1:0]      cause;
        logic [PA_W-1:0] paddr;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic  want_rsp = 1'b0;

    function automatic exp_t model(input int seg, input int ofs, input int acc);
        exp_t e;
        logic pok;
        e = '0;
        pok = (acc == 0) ? m_perm[seg][0] : (acc == 1) ? m_perm[seg][1] :
              (acc == 2) ? m_perm[seg][2] : 1'b0;
        if (seg >= int'(m_len) || !m_valid[seg]) begin e.trap = 1; e.cause = 2'b01; end
        else if (ofs >= int'(m_limit[seg]))      begin e.trap = 1; e.cause = 2'b10; end
        else if (!pok)                           begin e.trap = 1; e.cause = 2'b11; end
        else e.paddr = m_base[seg] + PA_W'(ofs);
        return e;
    endfunction

    task automatic idle();
        @(negedge clk);
        cfg_ent_we = 0; cfg_len_we = 0; req_valid = 0;
    endtask

    task automatic drive_req(input int seg, input int ofs, input int acc, input string tag);
        req_valid = 1; req_seg = SEG_W'(seg); req_ofs = OFS_W'(ofs); req_acc = 2'(acc);
        exp_q.push_back(model(seg, ofs, acc));
        tag_q.push_back(tag);
    endtask

    task automatic xlate(input int seg, input int ofs, input int acc, input string tag);
        @(negedge clk);
        cfg_ent_we = 0; cfg_len_we = 0;
        drive_req(seg, ofs, acc, tag);
    endtask

    task automatic drive_ent(input int idx, input int base, input int lim, input int perm, input bit v);
        cfg_ent_we = 1; cfg_ent_idx = SEG_W'(idx); cfg_ent_base = PA_W'(base);
        cfg_ent_limit = (OFS_W+1)'(lim); cfg_ent_perm = 3'(perm); cfg_ent_valid = v;
        m_base[idx] = PA_W'(base); m_limit[idx] = (OFS_W+1)'(lim);
        m_perm[idx] = 3'(perm); m_valid[idx] = v;
    endtask

    task automatic set_ent(input int idx, input int base, input int lim, input int perm, input bit v);
        @(negedge clk);
        cfg_len_we = 0; req_valid = 0;
        drive_ent(idx, base, lim, perm, v);
    endtask

    task automatic set_len(input int len);
        @(negedge clk);
        cfg_ent_we = 0; req_valid = 0;
        cfg_len_we = 1; cfg_len_val = (SEG_W+1)'(len); m_len = (SEG_W+1)'(len);
    endtask

    // request strobe captured at the edge that registers the result
    always @(posedge clk) want_rsp <= rst_n && req_valid;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (rsp_valid !== want_rsp) begin
                n_bad++;
                $display("FAIL R1 rsp_valid actual=%0b expected=%0b", rsp_valid, want_rsp);
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R1 unexpected response actual=1 expected=0");
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_chk++;
                    if ({rsp_trap, rsp_cause, rsp_paddr} !== e) begin
                        n_bad++;
                        $display("FAIL %s trap/cause/paddr actual=%0b/%0b/%h expected=%0b/%0b/%h",
                                 t, rsp_trap, rsp_cause, rsp_paddr, e.trap, e.cause, e.paddr);
                    end
                end
            end else if (rsp_trap !== 1'b0 || rsp_cause !== 2'b00) begin
                n_bad++;
                $display("FAIL R1 idle outputs actual=%0b/%0b expected=0/0", rsp_trap, rsp_cause);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_perm[i] = '0; m_valid[i] = 0;
        end
        m_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R9: reset state, no response and all requests trap
        @(negedge clk);
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 rsp_valid after reset actual=%0b expected=0", rsp_valid);
        end
        xlate(0, 0, 0, "R9");
        xlate(7, 5, 2, "R9");

        // R2: slot valid but length still zero
        set_ent(0, 16'h1000, 13'h100, 3'b011, 1);
        xlate(0, 16, 0, "R2");
        set_len(4);
        set_ent(1, 16'hFF00, 13'h200, 3'b100, 1);
        set_ent(2, 16'h3000, 13'h080, 3'b111, 0);
        set_ent(3, 16'h0000, 13'h1000, 3'b111, 1);
        set_ent(5, 16'h5000, 13'h100, 3'b111, 1);

        // back-to-back requests (R1)
        xlate(0, 16'h010, 0, "R7");
        xlate(0, 16'h0FF, 1, "R4");
        xlate(0, 16'h100, 0, "R4");
        xlate(0, 16'h020, 2, "R5");
        xlate(0, 16'h020, 3, "R5");
        xlate(1, 16'h1FF, 2, "R7");
        xlate(1, 16'h010, 0, "R5");
        xlate(2, 16'h010, 0, "R3");
        xlate(4, 16'h000, 0, "R2");
        xlate(5, 16'h000, 0, "R2");
        xlate(3, 16'hFFF, 0, "R7");
        idle();
        idle();

        // R6: priority
        xlate(0, 16'h200, 2, "R6");
        xlate(2, 16'hFFF, 3, "R6");
        set_len(1);
        xlate(3, 16'hFFF, 3, "R6");
        xlate(0, 16'h0FF, 1, "R6");
        set_len(8);
        xlate(5, 16'h0FF, 1, "R2");
        xlate(7, 16'h000, 0, "R3");

        // R10: write and request in the same cycle
        @(negedge clk);
        cfg_len_we = 0;
        drive_req(0, 16'h010, 0, "R10");
        drive_ent(0, 16'h2000, 13'h100, 3'b011, 1);
        // the model now holds the new slot; the request above saw the old one
        xlate(0, 16'h010, 0, "R10");
        // R11: other slots untouched
        xlate(3, 16'h123, 1, "R11");
        xlate(1, 16'h004, 2, "R11");
        idle();
        xlate(0, 16'h0FF, 0, "R7");
        idle();
        idle();
        idle();

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule